// File: doc/BRIEF.md
# Waveform Timer Counter Channel

This block is one channel of a general-purpose timer running in waveform-generation mode. A free-running counter advances on a qualified counting tick (the selected counting clock, presented as a one-cycle enable) and is compared against a programmable limit register, the RC value. The two mode bits choose up-only or up/down counting, each with or without an automatic restart when the count meets RC.

An external event can restart the count. The event is taken from one of four signals and qualified by a selectable edge. When trigger is enabled, the event clears the counter and (re)starts its counting clock. The event can be taken from the bidirectional waveform pin. In that case the pin stops driving, and the block reports this so the pad logic can turn it into an input. A separate control bit halts counting once the count lands on RC, until the next trigger.

Top module: `wave_tc`

## Requirements
- R1: After reset the count is 0, the RC flag is low, the counting clock is running and the direction is upward.
- R2: Mode 00 adds one per tick, wraps from all-ones to 0, ignores RC for counting purposes, and holds while the tick is low.
- R3: Mode 01 counts up, and the tick after the count equals RC loads 0.
- R4: Mode 10 counts up to all-ones, then down to 0, then up again. Each turn-around takes one tick.
- R5: Mode 11 counts up until the count equals RC, then down to 0, then up again.
- R6: Edge field: 00 means no edge, 01 rising, 10 falling, 11 either. An edge is seen when the current sample of the selected signal differs from the sample registered on the previous clock. With trigger enabled, a qualified edge clears the count on that clock edge, whether or not a tick is present.
- R7: Source field: 00 selects the waveform pin input, 01 selects external clock line 0, 10 selects line 1 and 11 selects line 2. Edges on signals that are not selected have no effect.
- R8: The pin-drive output is 0 while the source field is 00 and 1 for the other three sources.
- R9: With trigger enable at 0, no event changes the count or the counting clock.
- R10: With stop-on-RC set, the counter freezes at RC once it lands there. A trigger restarts it from 0.
- R11: A trigger wins over any RC action on the same clock. The count becomes 0, counting continues upward, and the counter is not stopped.
- R12: The RC flag is high for exactly the one cycle after an update writes a count equal to RC.
- R13: With the waveform-mode bit at 0, the count holds, triggers are ignored and the pin-drive output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counting-clock enable, one pulse per count |
| wave_en | input | 1 | Waveform-mode select; 1 = operate |
| cnt_mode | input | 2 | Counting mode (R2 to R5) |
| evt_edge | input | 2 | Event edge qualifier (R6) |
| evt_src | input | 2 | Event source select (R7) |
| evt_trig_en | input | 1 | Event trigger enable |
| stop_at_rc | input | 1 | Halt counting clock when count lands on RC |
| tiob_in | input | 1 | Waveform pin, sampled as an event source |
| xc_in | input | NUM_XC | External clock lines usable as events |
| rc_val | input | WIDTH | RC compare value |
| count | output | WIDTH | Counter value |
| rc_hit | output | 1 | One-cycle RC compare flag |
| tiob_drive | output | 1 | 1 when the waveform pin should drive |

## Verification
A wrong direction flag shows on the `count` port at the next tick after a turn-around point. The count moves by one in the wrong direction, so checks taken right at 0, at all-ones and at RC find it. A stuck run flag shows as a count that keeps moving past RC, or as a count that stays frozen after a trigger. Both appear within one or two ticks. A stale event sample from the edge detector shows as a spurious or missed clear on the clock right after the input changes. The bench therefore samples the count on the negative edge that follows each stimulus.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
   typedef enum logic [1:0] {
      CM_UP      = 2'b00,
      CM_UP_RC   = 2'b01,
      CM_UPDN    = 2'b10,
      CM_UPDN_RC = 2'b11
   } cnt_mode_e;

   typedef enum logic [1:0] {
      EG_NONE = 2'b00,
      EG_RISE = 2'b01,
      EG_FALL = 2'b10,
      EG_BOTH = 2'b11
   } edge_mode_e;
endpackage

// File: rtl/wtc_event.sv
`timescale 1ns/1ps
module wtc_event
   import wtc_pkg::*;
#(
   parameter int NUM_XC = 3,
   parameter int SRC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wave_i,
   input  logic [SRC_W-1:0]  src_i,
   input  logic [1:0]        edge_i,
   input  logic              trig_en_i,
   input  logic              tiob_i,
   input  logic [NUM_XC-1:0] xc_i,
   output logic              trig_o,
   output logic              tiob_drive_o
);
   localparam int NSRC = 2**SRC_W;

   if (NUM_XC + 1 > NSRC) begin : g_bad_src
      $error("wtc_event: NUM_XC+1 sources do not fit in SRC_W bits");
   end

   logic [NSRC-1:0] cand;
   assign cand[0] = tiob_i;
   for (genvar g = 1; g < NSRC; g++) begin : g_src
      if (g <= NUM_XC) begin : g_xc
         assign cand[g] = xc_i[g-1];
      end else begin : g_nc
         assign cand[g] = 1'b0;
      end
   end

   logic sel, sel_q, rise, fall, qual;
   assign sel = cand[src_i];

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel;
   end

   assign rise = sel & ~sel_q;
   assign fall = ~sel & sel_q;

   always_comb begin
      case (edge_mode_e'(edge_i))
         EG_RISE: qual = rise;
         EG_FALL: qual = fall;
         EG_BOTH: qual = rise | fall;
         default: qual = 1'b0;
      endcase
   end

   assign trig_o       = wave_i & trig_en_i & qual;
   assign tiob_drive_o = wave_i & (src_i != '0);

   // R6: a trigger only ever follows a change of the selected sample
   a_r6_edge_source: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> (sel != sel_q));
endmodule

// File: rtl/wtc_run.sv
`timescale 1ns/1ps
module wtc_run (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic land_rc_i,
   input  logic stop_en_i,
   output logic run_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)                      run_o <= 1'b1;
      else if (start_i)                run_o <= 1'b1;
      else if (stop_en_i && land_rc_i) run_o <= 1'b0;
   end

   // R11: a trigger leaves the clock running
   a_r11_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> run_o);
endmodule

// File: rtl/wtc_count.sv
`timescale 1ns/1ps
module wtc_count
   import wtc_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wave_i,
   input  logic [1:0]       mode_i,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             trig_i,
   input  logic [WIDTH-1:0] rc_i,
   output logic [WIDTH-1:0] count_o,
   output logic             rc_hit_o,
   output logic             land_rc_o
);
   logic [WIDTH-1:0] count_q, cnt_nxt;
   logic             dn_q, dn_nxt, upd;
   logic             at_rc, at_max, at_zero, turn_hi;
   cnt_mode_e        mode;

   assign mode    = cnt_mode_e'(mode_i);
   assign at_rc   = (count_q == rc_i);
   assign at_max  = (count_q == {WIDTH{1'b1}});
   assign at_zero = (count_q == '0);
   assign turn_hi = at_max | ((mode == CM_UPDN_RC) & at_rc);

   always_comb begin
      cnt_nxt = count_q;
      dn_nxt  = dn_q;
      upd     = 1'b0;
      if (!wave_i) begin
         upd = 1'b0;
      end else if (trig_i) begin
         cnt_nxt = '0;
         dn_nxt  = 1'b0;
         upd     = 1'b1;
      end else if (run_i && tick_i) begin
         upd = 1'b1;
         case (mode)
            CM_UP: begin
               cnt_nxt = count_q + 1'b1;
               dn_nxt  = 1'b0;
            end
            CM_UP_RC: begin
               cnt_nxt = at_rc ? '0 : count_q + 1'b1;
               dn_nxt  = 1'b0;
            end
            default: begin
               if (!dn_q) begin
                  if (turn_hi) begin
                     dn_nxt  = 1'b1;
                     cnt_nxt = at_zero ? count_q : count_q - 1'b1;
                  end else begin
                     cnt_nxt = count_q + 1'b1;
                  end
               end else if (at_zero) begin
                  dn_nxt  = 1'b0;
                  cnt_nxt = count_q + 1'b1;
               end else begin
                  cnt_nxt = count_q - 1'b1;
               end
            end
         endcase
      end
   end

   assign land_rc_o = upd & (cnt_nxt == rc_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         dn_q     <= 1'b0;
         rc_hit_o <= 1'b0;
      end else begin
         count_q  <= cnt_nxt;
         dn_q     <= dn_nxt;
         rc_hit_o <= land_rc_o;
      end
   end

   assign count_o = count_q;

   // R2: plain up mode advances by exactly one per tick
   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_i && mode == CM_UP && run_i && tick_i && !trig_i)
      |=> count_q == $past(count_q) + 1'b1);
   // R4: a downward count that reaches 0 turns upward
   a_r4_floor_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_i && mode_i[1] && run_i && tick_i && !trig_i && dn_q && at_zero)
      |=> count_q == 1);
   // R12: the flag only accompanies a count equal to RC
   a_r12_hit_match: assert property (@(posedge clk) disable iff (!rst_n)
      rc_hit_o |-> count_q == $past(rc_i));
   // R13: outside waveform mode nothing moves
   a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wave_i |=> $stable(count_q));
endmodule

// File: rtl/wave_tc.sv
`timescale 1ns/1ps
module wave_tc #(
   parameter int WIDTH  = 16,
   parameter int NUM_XC = 3,
   parameter int SRC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              wave_en,
   input  logic [1:0]        cnt_mode,
   input  logic [1:0]        evt_edge,
   input  logic [SRC_W-1:0]  evt_src,
   input  logic              evt_trig_en,
   input  logic              stop_at_rc,
   input  logic              tiob_in,
   input  logic [NUM_XC-1:0] xc_in,
   input  logic [WIDTH-1:0]  rc_val,
   output logic [WIDTH-1:0]  count,
   output logic              rc_hit,
   output logic              tiob_drive
);
   if (WIDTH < 2) begin : g_bad_width
      $error("wave_tc: WIDTH must be at least 2");
   end

   logic trig, run, land_rc;

   wtc_event #(.NUM_XC(NUM_XC), .SRC_W(SRC_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .wave_i(wave_en), .src_i(evt_src),
      .edge_i(evt_edge), .trig_en_i(evt_trig_en), .tiob_i(tiob_in),
      .xc_i(xc_in), .trig_o(trig), .tiob_drive_o(tiob_drive)
   );

   wtc_run u_run (
      .clk(clk), .rst_n(rst_n), .start_i(trig), .land_rc_i(land_rc),
      .stop_en_i(stop_at_rc), .run_o(run)
   );

   wtc_count #(.WIDTH(WIDTH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wave_i(wave_en), .mode_i(cnt_mode),
      .tick_i(cnt_tick), .run_i(run), .trig_i(trig), .rc_i(rc_val),
      .count_o(count), .rc_hit_o(rc_hit), .land_rc_o(land_rc)
   );

   // R6: a trigger clears the count on its edge
   a_r6_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> count == '0);
   // R10: a halted counter without trigger holds its value
   a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !trig) |=> $stable(count));
   // R8: the pin never drives while it is the event source
   a_r8_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
      tiob_drive |-> evt_src != '0);
endmodule

// File: tb/sim_wave_tc.sv
`timescale 1ns/1ps
module sim_wave_tc;
   localparam int W = 8;

   logic         clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wave = 1'b1;
   logic         trig_en = 1'b0, stop_rc = 1'b0, tiob = 1'b0;
   logic [1:0]   mode = 2'b00, edge_s = 2'b00, src = 2'b01;
   logic [2:0]   xc = 3'b000;
   logic [W-1:0] rc = '0;
   logic [W-1:0] count;
   logic         rc_hit, tiob_drv;
   int           checks = 0, errs = 0;
   bit           done = 1'b0;

   always #2.5 clk = ~clk;

   wave_tc #(.WIDTH(W), .NUM_XC(3), .SRC_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_tick(tick), .wave_en(wave),
      .cnt_mode(mode), .evt_edge(edge_s), .evt_src(src),
      .evt_trig_en(trig_en), .stop_at_rc(stop_rc), .tiob_in(tiob),
      .xc_in(xc), .rc_val(rc), .count(count), .rc_hit(rc_hit),
      .tiob_drive(tiob_drv)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s actual %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 1'b0; xc = '0; tiob = 1'b0; wave = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_ticks(int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset();
      mode = 2'b00; rc = 5; src = 2'b01; trig_en = 1'b0; stop_rc = 1'b0;
      do_reset();
      chk("R1 count", count, 0);
      chk("R1 flag", rc_hit, 0);
      chk("R8 drive xc0", tiob_drv, 1);
      run_ticks(1);
      chk("R1 runs up", count, 1);
   endtask

   task automatic t_up();
      mode = 2'b00; rc = 5;
      do_reset();
      run_ticks(5);
      chk("R12 count", count, 5);
      chk("R12 flag set", rc_hit, 1);
      run_ticks(1);
      chk("R2 past rc", count, 6);
      chk("R12 flag one cycle", rc_hit, 0);
      repeat (3) step();
      chk("R2 hold no tick", count, 6);
      run_ticks(250);
      chk("R2 wrap", count, 0);
   endtask

   task automatic t_up_rc();
      mode = 2'b01; rc = 9;
      do_reset();
      run_ticks(9);
      chk("R3 reach", count, 9);
      run_ticks(1);
      chk("R3 restart", count, 0);
      run_ticks(9);
      chk("R3 again", count, 9);
      chk("R3 flag", rc_hit, 1);
   endtask

   task automatic t_updn();
      mode = 2'b10; rc = 100;
      do_reset();
      run_ticks(255);
      chk("R4 top", count, 255);
      run_ticks(1);
      chk("R4 turn down", count, 254);
      run_ticks(254);
      chk("R4 bottom", count, 0);
      run_ticks(1);
      chk("R4 turn up", count, 1);
   endtask

   task automatic t_updn_rc();
      mode = 2'b11; rc = 4;
      do_reset();
      run_ticks(4);
      chk("R5 at rc", count, 4);
      run_ticks(1);
      chk("R5 turn down", count, 3);
      run_ticks(3);
      chk("R5 bottom", count, 0);
      run_ticks(1);
      chk("R5 turn up", count, 1);
   endtask

   task automatic t_edges();
      mode = 2'b00; rc = 200; trig_en = 1'b1; src = 2'b01; edge_s = 2'b01;
      do_reset();
      run_ticks(10);
      chk("R6 pre", count, 10);
      tick = 1'b1;
      xc[0] = 1'b1; step(); chk("R6 rise clears", count, 0);
      xc[0] = 1'b0; step(); chk("R6 fall ignored", count, 1);
      edge_s = 2'b10;
      xc[0] = 1'b1; step(); chk("R6 rise ignored", count, 2);
      xc[0] = 1'b0; step(); chk("R6 fall clears", count, 0);
      edge_s = 2'b11;
      step();
      xc[0] = 1'b1; step(); chk("R6 both rise", count, 0);
      step();
      xc[0] = 1'b0; step(); chk("R6 both fall", count, 0);
      edge_s = 2'b00;
      step();
      xc[0] = 1'b1; step(); chk("R6 none", count, 2);
      xc[0] = 1'b0; step(); chk("R6 none fall", count, 3);
      tick = 1'b0;
   endtask

   task automatic t_sources();
      mode = 2'b00; rc = 200; trig_en = 1'b1; edge_s = 2'b01; src = 2'b10;
      do_reset();
      chk("R8 drive xc1", tiob_drv, 1);
      tick = 1'b1;
      step(); chk("R7 base", count, 1);
      xc[0] = 1'b1; step(); chk("R7 xc0 unselected", count, 2);
      xc[0] = 1'b0; step(); chk("R7 quiet", count, 3);
      xc[1] = 1'b1; step(); chk("R7 xc1 clears", count, 0);
      xc[1] = 1'b0; step();
      src = 2'b11; step(); chk("R7 switch", count, 2);
      xc[1] = 1'b1; step(); chk("R7 xc1 unselected", count, 3);
      xc[2] = 1'b1; step(); chk("R7 xc2 clears", count, 0);
      xc = '0; step();
      src = 2'b00; step();
      chk("R8 pin input", tiob_drv, 0);
      chk("R7 pin base", count, 2);
      tiob = 1'b1; step(); chk("R7 pin clears", count, 0);
      tiob = 1'b0; step(); chk("R7 pin fall", count, 1);
      tick = 1'b0;
      src = 2'b01;
   endtask

   task automatic t_trig_off();
      mode = 2'b00; rc = 200; trig_en = 1'b0; src = 2'b01; edge_s = 2'b11;
      do_reset();
      tick = 1'b1;
      step();
      xc[0] = 1'b1; step(); chk("R9 rise no effect", count, 2);
      xc[0] = 1'b0; step(); chk("R9 fall no effect", count, 3);
      tick = 1'b0;
   endtask

   task automatic t_stop();
      mode = 2'b00; rc = 6; stop_rc = 1'b1; trig_en = 1'b1; edge_s = 2'b01;
      src = 2'b01;
      do_reset();
      run_ticks(6);
      chk("R10 reach", count, 6);
      chk("R12 flag at stop", rc_hit, 1);
      run_ticks(5);
      chk("R10 frozen", count, 6);
      chk("R12 flag not repeated", rc_hit, 0);
      xc[0] = 1'b1; step();
      chk("R10 trigger clears", count, 0);
      xc[0] = 1'b0;
      run_ticks(2);
      chk("R10 restarted", count, 2);
      stop_rc = 1'b0;
   endtask

   task automatic t_priority();
      mode = 2'b11; rc = 3; stop_rc = 1'b0; trig_en = 1'b1; edge_s = 2'b01;
      src = 2'b01;
      do_reset();
      run_ticks(3);
      chk("R11 at rc", count, 3);
      tick = 1'b1; xc[0] = 1'b1; step();
      chk("R11 trig over turn", count, 0);
      xc[0] = 1'b0; step();
      chk("R11 counts up", count, 1);
      tick = 1'b0;
      mode = 2'b00; stop_rc = 1'b1;
      do_reset();
      run_ticks(2);
      tick = 1'b1; xc[0] = 1'b1; step();
      chk("R11 trig over stop", count, 0);
      xc[0] = 1'b0;
      repeat (3) step();
      chk("R11 reaches rc", count, 3);
      step();
      chk("R11 then stops", count, 3);
      tick = 1'b0; stop_rc = 1'b0;
   endtask

   task automatic t_wave_off();
      mode = 2'b00; rc = 200; trig_en = 1'b1; edge_s = 2'b01; src = 2'b01;
      do_reset();
      run_ticks(4);
      wave = 1'b0;
      step();
      chk("R13 no drive", tiob_drv, 0);
      run_ticks(3);
      chk("R13 hold", count, 4);
      xc[0] = 1'b1; step();
      chk("R13 trig ignored", count, 4);
      xc[0] = 1'b0; step();
      wave = 1'b1;
      run_ticks(1);
      chk("R13 resumes", count, 5);
   endtask

   initial begin
      t_reset();
      t_up();
      t_up_rc();
      t_updn();
      t_updn_rc();
      t_edges();
      t_sources();
      t_trig_off();
      t_stop();
      t_priority();
      t_wave_off();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errs++;
         $display("FAIL watchdog actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end
endmodule